// File: doc/BRIEF.md
# Residue Number System ALU

This block performs arithmetic on integers held in residue form over the pairwise coprime moduli 8, 7, 5 and 3. These moduli give a dynamic range of 840. Each operand is a packed word of four residue digits. A 2-bit opcode chooses one of four operations: sum, difference, product, or negation of the first operand. Every digit goes through its own modular channel, and no carry or other signal crosses from one digit to another. The longest logic path is therefore set by the widest digit and not by the full 11-bit word.

A caller presents both operands, the opcode and a valid strobe in one cycle. The packed result and its valid flag appear on the registered outputs one clock later. The moduli are parameters, and the digit widths and packing offsets are derived from them. A modulus that is a power of two takes a cheaper wraparound variant of each channel. Other moduli use compare-and-subtract reduction.

Top module: `rns_alu`

## Requirements
- R1: Packed words carry the modulus-8 digit in bits [10:8], the modulus-7 digit in [7:5], the modulus-5 digit in [4:2] and the modulus-3 digit in [1:0]. The opcode values are 00 sum, 01 difference, 10 product and 11 negate.
- R2: The sum opcode adds each digit pair modulo that digit's modulus. For example, (5,5,0,2) plus (7,6,4,2) gives (4,4,4,1).
- R3: The difference opcode adds each digit of the first operand to the modular complement of the matching digit of the second operand.
- R4: The product opcode multiplies each digit pair modulo its modulus. For example, (5,5,0,2) times (7,6,4,2) gives (3,2,0,1).
- R5: The negate opcode turns each nonzero digit d of the first operand into m − d and leaves a zero digit at zero. For example, (5,0,1,0) becomes (3,0,4,0). The second operand has no effect on this result.
- R6: A digit that wraps past its modulus affects no other digit. For example, (7,6,4,2) plus (1,1,1,1) gives (0,0,0,0).
- R7: The result is registered. out_valid is high exactly one cycle after in_valid was high. The result holds its value after any cycle in which in_valid was low.
- R8: A synchronous active-high reset clears out_valid and the result to zero.
- R9: For operands whose digits are in range, every result digit lies in 0 to m−1 for its modulus m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 2 | Operation select |
| opnd_a | input | 11 | First packed residue operand |
| opnd_b | input | 11 | Second packed residue operand |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 11 | Packed residue result |

## Verification
The bench derives every expected word from the integer value by the Chinese remainder mapping. It never mirrors the per-digit logic. A channel that leaked a carry into its neighbour, or that reduced with the wrong modulus, would therefore give a word that maps back to the wrong integer.

The stimulus aims at the wrap points. It uses the value 839 (all digits at their maximum) plus one, zero operands under negate and difference, and products whose raw digit products exceed the modulus several times over. A negate that passed a zero digit through as m, or a power-of-two channel that used the subtract path wrongly, would be caught by these cases.

The bench also sends negates with varying second operands, to catch a multiplexer that leaked the second operand into the result. Idle gaps and a reset in the middle of traffic show whether the result register holds its value and whether the valid flag stays aligned with its data.

// File: rtl/rns_pkg.sv
package rns_pkg;

   typedef enum logic [1:0] {
      RNS_ADD = 2'b00,
      RNS_SUB = 2'b01,
      RNS_MUL = 2'b10,
      RNS_NEG = 2'b11
   } rns_op_e;

   function automatic int unsigned gcd_u(int unsigned x, int unsigned y);
      int unsigned p;
      int unsigned q;
      int unsigned t;
      p = x;
      q = y;
      while (q != 0) begin
         t = p % q;
         p = q;
         q = t;
      end
      return p;
   endfunction

   function automatic bit is_pow2(int unsigned m);
      return (m != 0) && ((m & (m - 1)) == 0);
   endfunction

endpackage

// File: rtl/rns_mod_add.sv
module rns_mod_add #(
   parameter int unsigned MODULUS = 7,
   parameter int unsigned W       = $clog2(MODULUS)
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   localparam logic [W:0] MV = (W+1)'(MODULUS);

   generate
      if (rns_pkg::is_pow2(MODULUS)) begin : g_wrap
         always_comb y = a + b;
      end else begin : g_csub
         logic [W:0] sum;
         logic [W:0] diff;
         always_comb begin
            sum  = {1'b0, a} + {1'b0, b};
            diff = sum - MV;
            y    = (sum >= MV) ? diff[W-1:0] : sum[W-1:0];
         end
      end
   endgenerate

   // R2: subtracting a back out of y modulo m must recover b
   logic [W:0] back;
   always_comb begin
      back = ({1'b0, y} >= {1'b0, a}) ? ({1'b0, y} - {1'b0, a})
                                      : ({1'b0, y} + MV - {1'b0, a});
      if (({1'b0, a} < MV) && ({1'b0, b} < MV)) begin
         a_r2_add_inverse : assert (back == {1'b0, b})
            else $error("modular add inverse mismatch");
         a_r9_add_range : assert ({1'b0, y} < MV)
            else $error("modular add out of range");
      end
   end
endmodule

// File: rtl/rns_mod_neg.sv
module rns_mod_neg #(
   parameter int unsigned MODULUS = 7,
   parameter int unsigned W       = $clog2(MODULUS)
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   localparam logic [W:0] MV = (W+1)'(MODULUS);

   generate
      if (rns_pkg::is_pow2(MODULUS)) begin : g_wrap
         always_comb y = '0 - a;
      end else begin : g_cmp
         localparam logic [W-1:0] MW = W'(MODULUS);
         always_comb y = (a == '0) ? '0 : (MW - a);
      end
   endgenerate

   // R5: a + (-a) is zero modulo m
   always_comb begin
      if ({1'b0, a} < MV) begin
         if (a == '0) begin
            a_r5_neg_zero : assert (y == '0) else $error("negated zero not zero");
         end else begin
            a_r5_neg_sum : assert (({1'b0, a} + {1'b0, y}) == MV)
               else $error("digit plus complement not equal to modulus");
         end
      end
   end
endmodule

// File: rtl/rns_mod_mul.sv
module rns_mod_mul #(
   parameter int unsigned MODULUS = 7,
   parameter int unsigned W       = $clog2(MODULUS)
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   localparam int unsigned PW = 2 * W;
   localparam logic [W:0]  MV = (W+1)'(MODULUS);

   logic [PW-1:0] prod;
   always_comb prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

   generate
      if (rns_pkg::is_pow2(MODULUS)) begin : g_wrap
         always_comb y = prod[W-1:0];
      end else begin : g_rem
         localparam logic [PW-1:0] MP = PW'(MODULUS);
         logic [PW-1:0] rem;
         always_comb begin
            rem = prod % MP;
            y   = rem[W-1:0];
         end
      end
   endgenerate

   always_comb begin
      if (({1'b0, a} < MV) && ({1'b0, b} < MV)) begin
         a_r9_mul_range : assert ({1'b0, y} < MV) else $error("modular product out of range");
      end
   end
endmodule

// File: rtl/rns_lane.sv
module rns_lane
   import rns_pkg::*;
#(
   parameter int unsigned MODULUS = 7,
   parameter int unsigned W       = $clog2(MODULUS)
) (
   input  rns_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   logic [W-1:0] neg_in;
   logic [W-1:0] neg_out;
   logic [W-1:0] add_b;
   logic [W-1:0] add_out;
   logic [W-1:0] mul_out;

   // one complement unit serves both difference (on b) and negate (on a)
   always_comb neg_in = (op == RNS_NEG) ? a : b;
   always_comb add_b  = (op == RNS_SUB) ? neg_out : b;

   rns_mod_neg #(.MODULUS(MODULUS), .W(W)) u_neg (.a(neg_in), .y(neg_out));
   rns_mod_add #(.MODULUS(MODULUS), .W(W)) u_add (.a(a), .b(add_b), .y(add_out));
   rns_mod_mul #(.MODULUS(MODULUS), .W(W)) u_mul (.a(a), .b(b), .y(mul_out));

   always_comb begin
      unique case (op)
         RNS_ADD, RNS_SUB: y = add_out;
         RNS_MUL:          y = mul_out;
         default:          y = neg_out;
      endcase
   end
endmodule

// File: rtl/rns_alu.sv
module rns_alu
   import rns_pkg::*;
#(
   parameter int unsigned NUM_DIGITS = 4,
   parameter int unsigned MODULI [NUM_DIGITS] = '{8, 7, 5, 3},
   parameter int unsigned PACK_W = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        op,
   input  logic [PACK_W-1:0] opnd_a,
   input  logic [PACK_W-1:0] opnd_b,
   output logic              out_valid,
   output logic [PACK_W-1:0] result
);
   // digit 0 is the most significant field of the packed word
   function automatic int unsigned digit_w(int unsigned i);
      return $clog2(MODULI[i]);
   endfunction

   function automatic int unsigned digit_lo(int unsigned i);
      int unsigned s;
      s = 0;
      for (int unsigned j = i + 1; j < NUM_DIGITS; j++) s += digit_w(j);
      return s;
   endfunction

   localparam int unsigned TOTAL_W = digit_lo(0) + digit_w(0);

   initial begin
      a_cfg_width : assert (TOTAL_W == PACK_W)
         else $error("PACK_W does not match the sum of digit widths");
      for (int unsigned i = 0; i < NUM_DIGITS; i++) begin
         a_cfg_min : assert (MODULI[i] >= 2) else $error("modulus below 2");
         for (int unsigned j = i + 1; j < NUM_DIGITS; j++) begin
            a_cfg_coprime : assert (gcd_u(MODULI[i], MODULI[j]) == 1)
               else $error("moduli not pairwise coprime");
         end
      end
   end

   rns_op_e           op_e;
   logic [PACK_W-1:0] next_res;

   always_comb op_e = rns_op_e'(op);

   generate
      for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_lane
         localparam int unsigned LW = digit_w(gi);
         localparam int unsigned LO = digit_lo(gi);
         rns_lane #(.MODULUS(MODULI[gi]), .W(LW)) u_lane (
            .op (op_e),
            .a  (opnd_a[LO +: LW]),
            .b  (opnd_b[LO +: LW]),
            .y  (next_res[LO +: LW])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end

   a_r7_valid_follows : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid) else $error("out_valid missing after in_valid");
   a_r7_no_spurious : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid) else $error("out_valid without in_valid");
   a_r7_hold : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result)) else $error("result changed while idle");
   a_r8_reset_clears : assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0)) else $error("reset did not clear outputs");
endmodule

// File: tb/rns_alu_bench.sv
module rns_alu_bench;
   localparam int RANGE = 840;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [1:0]  op;
   logic [10:0] opnd_a;
   logic [10:0] opnd_b;
   logic        out_valid;
   logic [10:0] result;

   always #5 clk = ~clk;

   rns_alu u_rns_alu (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
   );

   typedef struct {
      logic [10:0] res;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 0;
   logic [10:0] last_res = '0;

   function automatic int norm(int x);
      return ((x % RANGE) + RANGE) % RANGE;
   endfunction

   // R1 packing: mod8 [10:8], mod7 [7:5], mod5 [4:2], mod3 [1:0]
   function automatic logic [10:0] enc(int x);
      int v;
      v = norm(x);
      return {3'(v % 8), 3'(v % 7), 3'(v % 5), 2'(v % 3)};
   endfunction

   task automatic check(input logic [10:0] got, input logic [10:0] exp, input string tag);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [1:0] o, input int xa, input int xb, input string tag);
      exp_t e;
      int   r;
      @(negedge clk);
      in_valid = 1'b1;
      op       = o;
      opnd_a   = enc(xa);
      opnd_b   = enc(xb);
      case (o)
         2'b00:   r = xa + xb;
         2'b01:   r = xa - xb;
         2'b10:   r = norm(xa) * norm(xb);
         default: r = -xa;
      endcase
      e.res = enc(r);
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         opnd_a   = enc(k * 97 + 13);
         opnd_b   = enc(k * 61 + 5);
         op       = 2'(k);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst) begin
            last_res = '0;
         end else if (out_valid) begin
            if (sb.size() == 0) begin
               n_checks++;
               n_fails++;
               $display("FAIL R7: got out_valid=1 expected out_valid=0 (nothing pending)");
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(result, e.res, e.tag);
            end
            last_res = result;
         end else begin
            check(result, last_res, "R7 hold while idle");
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      rst      = 1'b1;
      in_valid = 1'b0;
      op       = 2'b00;
      opnd_a   = '0;
      opnd_b   = '0;
      repeat (3) @(negedge clk);
      #1;
      check({10'b0, out_valid}, 11'd0, "R8 reset out_valid");
      check(result, 11'd0, "R8 reset result");
      @(negedge clk);
      rst = 1'b0;

      // directed cases
      drive(2'b00, 5, -1, "R1 R2 add 5 + -1");
      drive(2'b10, 5, -1, "R4 mul 5 * -1");
      drive(2'b11, 21, 300, "R5 negate 21");
      drive(2'b11, 21, 17, "R5 negate ignores b");
      drive(2'b11, 0, 839, "R5 negate zero");
      drive(2'b00, 839, 1, "R6 wrap all digits");
      drive(2'b01, 0, 1, "R3 0 - 1");
      drive(2'b01, 100, 100, "R3 x - x");
      drive(2'b01, 3, 839, "R3 3 - (-1)");
      drive(2'b10, 839, 839, "R4 R9 max * max");
      drive(2'b10, 0, 555, "R4 zero product");
      idle(2);
      drive(2'b00, 420, 420, "R6 R2 half range doubled");
      idle(1);

      // sweep
      for (int i = 0; i < 400; i++) begin
         drive(2'(i % 4), (i * 37 + 11) % RANGE, (i * 53 + 5) % RANGE, "R2 R3 R4 R5 R9 sweep");
         if (i % 9 == 0) idle(1 + (i % 3));
      end
      idle(3);

      // reset in the middle of traffic
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b1;
      op       = 2'b00;
      opnd_a   = enc(123);
      opnd_b   = enc(456);
      @(negedge clk);
      @(negedge clk);
      #1;
      check({10'b0, out_valid}, 11'd0, "R8 reset with valid input");
      check(result, 11'd0, "R8 reset result mid traffic");
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      drive(2'b00, 123, 456, "R7 after reset");
      idle(4);
      check(11'(sb.size()), 11'd0, "R7 every input produced one output");

      done = 1;
      finish_run();
   end
endmodule